// File: doc/BRIEF.md
# UART with FIFOs and Hardware Flow Control

This block is a full-duplex asynchronous serial port. Software writes bytes into a 16-entry transmit queue and reads received bytes out of a 16-entry receive queue through a small byte-wide register bus laid out in the familiar 16550 arrangement. The bit clock comes from a 16x oversampling tick made by an integer divisor plus a fractional accumulator that stretches a tick period by one clock whenever it wraps. With that stretch, standard rates can be produced from input clocks that are not a multiple of the baud rate. Frames are fixed at 8 data bits, no parity, one stop bit. A single level interrupt reports line errors, received data at a programmable fill level, a receive character timeout and an empty transmit queue.

Hardware flow control is optional and works without software. With automatic CTS on, a low-active `cts_n` held high stops the transmitter from starting a new character, but a character already on the line finishes. With automatic RTS on, `rts_n` goes high (deasserted) once the receive queue holds at least the trigger level and returns low when it drops below that level.

The transmitter state machine has four states. It moves from Idle to Start on a tick when the queue has a byte and CTS permits it, and this move pops the byte. It moves from Start to Data after 16 ticks, from Data to Stop after the eighth data bit's 16 ticks, and from Stop back to Idle after 16 ticks. The receiver also has four states. It moves from Idle to Start on a tick that sees the line low. From Start it goes to Data if the line is still low on the 8th tick, or back to Idle if the line is high again. It moves from Data to Stop after eight mid-bit samples, and from Stop to Idle at the stop bit's mid-point, where it writes the byte into the receive queue.

Top module: `serial_port`

## Requirements
- R1: Each queue holds 16 bytes. A byte that arrives while the receive queue already holds 16 is dropped and sets the overrun bit. The 16 held bytes read back in arrival order.
- R2: FIFO-control write (offset 2) bits 7:6 set the receive trigger: 00=1, 01=4, 10=8, 11=14 bytes. Bits 1 and 2 of the same write empty the receive and transmit queues. With interrupt-enable bit 0 set, the ID reads 0x04 while the fill level is at or above the trigger.
- R3: Setting line-control (offset 3) bit 7 maps offsets 0 and 1 to the divisor low and high bytes (reset value 1). Clearing it maps offset 0 to receive-read/transmit-write and offset 1 to interrupt enable. Line control reads back bit 7 with 0x03 in its low bits.
- R4: An oversample tick occurs every D clocks, where D is the divisor. The fractional register (offset 6: modulus in bits 7:4, add value in bits 3:0; reset 0x10) lengthens one tick period by a clock each time its accumulator wraps. A bit lasts 16 ticks, so D=3 gives a 48-clock start bit, and D=2 with modulus 2 and add 1 gives 40 clocks.
- R5: With automatic CTS (offset 4 bit 1) on, no character starts while `cts_n` is high, and a character already started completes.
- R6: With automatic RTS (offset 4 bit 0) on, `rts_n` is high when the receive fill level is at or above the trigger and low below it. With it off, `rts_n` is the inverse of offset 4 bit 2.
- R7: The receiver confirms a start bit on the 8th tick after it first sees the line low, ignores any low pulse shorter than that, and samples each data bit at mid-bit.
- R8: `txd` idles high and sends a low start bit, 8 data bits LSB first, then a high stop bit.
- R9: Line status (offset 5) has bit 0 data ready, bit 1 overrun, bit 3 framing error (stop sampled low), bit 5 transmit queue empty, and bit 6 transmit queue empty with the shifter idle. Bits 1 and 3 clear when line status is read.
- R10: With interrupt-enable bit 0 set, a non-empty receive queue that sees no write and no read for 640 ticks (four character times) gives ID 0x0C.
- R11: The interrupt ID (offset 2 read) gives priority to line error 0x06 (enable bit 2), then received data 0x04, then timeout 0x0C, then transmit empty 0x02 (enable bit 1), then none 0x01. `irq` is high exactly when ID bit 0 is 0.
- R12: After reset `txd` and `rts_n` are high, `irq` is low, line status reads 0x60 and the ID reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| irq | output | 1 | Interrupt request, active high |

## Verification
A transmitter stuck in the wrong state shows on `txd` within one bit time: a start bit of the wrong width, a bit out of place, or a missing stop bit, which the bench decodes and compares. A wrong receiver count or a false start confirmation shows up as a wrong byte, or as a spurious data-ready bit, once the frame ends. Queue pointer or count errors surface as wrong read order, a missing overrun or a wrong `rts_n` level on the next queue operation. Errors in the divisor or accumulator shift the start-bit width, which the bench measures to the clock.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;
    typedef enum logic [1:0] {T_IDLE, T_START, T_DATA, T_STOP} tx_state_t;
    typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_state_t;

    localparam int DIV_W       = 16;
    localparam int FRAC_W      = 4;
    localparam int OS_W        = 4;
    localparam logic [OS_W-1:0] OS_LAST = 4'd15;
    localparam logic [OS_W-1:0] OS_MID  = 4'd7;
    localparam int FRAME_TICKS = 10 * 16;

    localparam logic [3:0] IID_NONE = 4'h1;
    localparam logic [3:0] IID_LINE = 4'h6;
    localparam logic [3:0] IID_RDA  = 4'h4;
    localparam logic [3:0] IID_CTO  = 4'hC;
    localparam logic [3:0] IID_THR  = 4'h2;

    function automatic logic [4:0] trig_level(input logic [1:0] code);
        logic [4:0] lvl;
        unique case (code)
            2'b00: lvl = 5'd1;
            2'b01: lvl = 5'd4;
            2'b10: lvl = 5'd8;
            2'b11: lvl = 5'd14;
        endcase
        return lvl;
    endfunction
endpackage

// File: rtl/sp_fifo.sv
`timescale 1ns/1ps
module sp_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R1: a write into a full queue leaves it full and unchanged in size
    p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && !clr && count == CW'(DEPTH) |=> count == CW'(DEPTH));
endmodule

// File: rtl/sp_baud.sv
`timescale 1ns/1ps
module sp_baud import sp_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic [FRAC_W-1:0] frac_mod,
    input  logic [FRAC_W-1:0] frac_add,
    output logic              tick
);
    logic [DIV_W:0]    cnt, period;
    logic [DIV_W-1:0]  div_eff;
    logic [FRAC_W-1:0] mod_eff, acc;
    logic [FRAC_W:0]   sum;
    logic              stretch;

    always_comb begin
        div_eff = (div == '0) ? DIV_W'(1) : div;
        mod_eff = (frac_mod == '0) ? FRAC_W'(1) : frac_mod;
        period  = {1'b0, div_eff} + (DIV_W+1)'(stretch);
        tick    = (cnt >= period - 1'b1);
        sum     = {1'b0, acc} + {1'b0, frac_add};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            acc     <= '0;
            stretch <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            if (sum >= {1'b0, mod_eff}) begin
                stretch <= 1'b1;
                acc     <= FRAC_W'(sum - {1'b0, mod_eff});
            end else begin
                stretch <= 1'b0;
                acc     <= sum[FRAC_W-1:0];
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: with a divisor above one, ticks never come on consecutive clocks
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick && div_eff > DIV_W'(1) |=> !tick || div_eff == DIV_W'(1));
endmodule

// File: rtl/sp_tx.sv
`timescale 1ns/1ps
module sp_tx import sp_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    input  logic       auto_cts,
    input  logic       cts_n,
    output logic       pop,
    output logic       txd,
    output logic       busy
);
    tx_state_t       state, nxt;
    logic [OS_W-1:0] os;
    logic [2:0]      bitn;
    logic [7:0]      shreg;
    logic [1:0]      cts_sync;
    logic            cts_s, go, bit_end;

    assign cts_s   = cts_sync[1];
    assign go      = tick && !q_empty && !(auto_cts && cts_s);
    assign bit_end = tick && (os == OS_LAST);

    always_comb begin
        nxt = state;
        unique case (state)
            T_IDLE:  if (go) nxt = T_START;
            T_START: if (bit_end) nxt = T_DATA;
            T_DATA:  if (bit_end && bitn == 3'd7) nxt = T_STOP;
            T_STOP:  if (bit_end) nxt = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= T_IDLE;
            os       <= '0;
            bitn     <= '0;
            shreg    <= '0;
            cts_sync <= 2'b11;
        end else begin
            state    <= nxt;
            cts_sync <= {cts_sync[0], cts_n};
            if (state == T_IDLE || state != nxt) os <= '0;
            else if (tick) os <= os + 1'b1;
            if (state == T_IDLE && go) begin
                shreg <= q_data;
                bitn  <= '0;
            end else if (state == T_DATA && bit_end) begin
                shreg <= {1'b0, shreg[7:1]};
                bitn  <= bitn + 1'b1;
            end
        end
    end

    always_comb begin
        pop  = 1'b0;
        txd  = 1'b1;
        busy = 1'b1;
        unique case (state)
            T_IDLE:  begin pop = go; busy = 1'b0; end
            T_START: txd = 1'b0;
            T_DATA:  txd = shreg[0];
            T_STOP:  txd = 1'b1;
        endcase
    end

    // R5: a blocked clear-to-send holds the transmitter idle
    p_cts_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == T_IDLE && auto_cts && cts_s |=> state == T_IDLE);
    // R8: the stop bit is only ever followed by idle
    p_stop_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == T_STOP |=> state == T_STOP || state == T_IDLE);
endmodule

// File: rtl/sp_rx.sv
`timescale 1ns/1ps
module sp_rx import sp_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    output logic       push,
    output logic [7:0] data,
    output logic       ferr
);
    rx_state_t       state, nxt;
    logic [OS_W-1:0] os;
    logic [2:0]      bitn;
    logic [7:0]      shreg;
    logic [1:0]      rx_sync;
    logic            rx_s;

    assign rx_s = rx_sync[1];

    always_comb begin
        nxt = state;
        unique case (state)
            R_IDLE:  if (tick && !rx_s) nxt = R_START;
            R_START: if (tick && os == OS_MID) nxt = rx_s ? R_IDLE : R_DATA;
            R_DATA:  if (tick && os == OS_LAST && bitn == 3'd7) nxt = R_STOP;
            R_STOP:  if (tick && os == OS_LAST) nxt = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= R_IDLE;
            os      <= '0;
            bitn    <= '0;
            shreg   <= '0;
            rx_sync <= 2'b11;
        end else begin
            state   <= nxt;
            rx_sync <= {rx_sync[0], rxd};
            if (state == R_IDLE || state != nxt) os <= '0;
            else if (tick) os <= os + 1'b1;
            if (state == R_START) bitn <= '0;
            else if (state == R_DATA && tick && os == OS_LAST) begin
                shreg <= {rx_s, shreg[7:1]};
                bitn  <= bitn + 1'b1;
            end
        end
    end

    always_comb begin
        push = 1'b0;
        data = shreg;
        ferr = 1'b0;
        unique case (state)
            R_IDLE, R_START, R_DATA: ;
            R_STOP: begin
                push = tick && (os == OS_LAST);
                ferr = !rx_s;
            end
        endcase
    end

    // R7: data sampling only begins after the line was seen low at mid start bit
    p_start_confirm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == R_DATA) |-> $past(!rx_s));
endmodule

// File: rtl/serial_port.sv
`timescale 1ns/1ps
module serial_port import sp_pkg::*; #(
    parameter int FIFO_DEPTH = 16,
    parameter int TO_CHARS   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rxd,
    output logic       txd,
    input  logic       cts_n,
    output logic       rts_n,
    output logic       irq
);
    localparam int CW       = $clog2(FIFO_DEPTH+1);
    localparam int TO_TICKS = TO_CHARS * FRAME_TICKS;
    localparam int TO_W     = $clog2(TO_TICKS+1);

    logic [2:0]        ier, flow;
    logic              dlab, oe, fe;
    logic [DIV_W-1:0]  div;
    logic [FRAC_W-1:0] frac_mod, frac_add;
    logic [1:0]        trig;
    logic [TO_W-1:0]   to_cnt;
    logic [3:0]        iid;
    logic [7:0]        lsr;

    logic          tick;
    logic          tx_push, tx_pop, tx_clr, tx_busy, tx_empty;
    logic [7:0]    tx_dout;
    logic [CW-1:0] tx_count;
    logic          rx_push, rx_pop, rx_clr, rx_ferr, rx_full, rx_empty, lsr_rd;
    logic          at_trig, to_hit;
    logic [7:0]    rx_data, rx_dout;
    logic [CW-1:0] rx_count;

    assign tx_push  = wr_en && addr == 3'd0 && !dlab;
    assign rx_pop   = rd_en && addr == 3'd0 && !dlab;
    assign lsr_rd   = rd_en && addr == 3'd5;
    assign tx_clr   = wr_en && addr == 3'd2 && wdata[2];
    assign rx_clr   = wr_en && addr == 3'd2 && wdata[1];
    assign tx_empty = tx_count == '0;
    assign rx_empty = rx_count == '0;
    assign rx_full  = rx_count == CW'(FIFO_DEPTH);
    assign at_trig  = rx_count >= CW'(trig_level(trig));
    assign to_hit   = to_cnt == TO_W'(TO_TICKS);

    sp_baud u_baud (.clk, .rst_n, .div, .frac_mod, .frac_add, .tick);

    sp_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk, .rst_n, .clr(tx_clr), .push(tx_push), .din(wdata),
        .pop(tx_pop), .dout(tx_dout), .count(tx_count));

    sp_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk, .rst_n, .clr(rx_clr), .push(rx_push), .din(rx_data),
        .pop(rx_pop), .dout(rx_dout), .count(rx_count));

    sp_tx u_tx (.clk, .rst_n, .tick, .q_empty(tx_empty), .q_data(tx_dout),
        .auto_cts(flow[1]), .cts_n, .pop(tx_pop), .txd, .busy(tx_busy));

    sp_rx u_rx (.clk, .rst_n, .tick, .rxd, .push(rx_push), .data(rx_data),
        .ferr(rx_ferr));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier      <= '0;
            flow     <= '0;
            dlab     <= 1'b0;
            div      <= DIV_W'(1);
            frac_mod <= FRAC_W'(1);
            frac_add <= '0;
            trig     <= '0;
            oe       <= 1'b0;
            fe       <= 1'b0;
            to_cnt   <= '0;
        end else begin
            if (wr_en) begin
                case (addr)
                    3'd0: if (dlab) div[7:0] <= wdata;
                    3'd1: if (dlab) div[15:8] <= wdata; else ier <= wdata[2:0];
                    3'd2: trig <= wdata[7:6];
                    3'd3: dlab <= wdata[7];
                    3'd4: flow <= wdata[2:0];
                    3'd6: begin
                        frac_mod <= wdata[7:4];
                        frac_add <= wdata[3:0];
                    end
                    default: ;
                endcase
            end
            if (rx_push && rx_full) oe <= 1'b1;
            else if (lsr_rd) oe <= 1'b0;
            if (rx_push && rx_ferr && !rx_full) fe <= 1'b1;
            else if (lsr_rd) fe <= 1'b0;
            if (rx_empty || rx_push || rx_pop || rx_clr) to_cnt <= '0;
            else if (tick && !to_hit) to_cnt <= to_cnt + 1'b1;
        end
    end

    always_comb begin
        lsr = {1'b0, tx_empty && !tx_busy, tx_empty, 1'b0, fe, 1'b0, oe, !rx_empty};
        if (ier[2] && (oe || fe))   iid = IID_LINE;
        else if (ier[0] && at_trig) iid = IID_RDA;
        else if (ier[0] && to_hit)  iid = IID_CTO;
        else if (ier[1] && tx_empty) iid = IID_THR;
        else                        iid = IID_NONE;
        irq   = !iid[0];
        rts_n = flow[0] ? at_trig : !flow[2];
        case (addr)
            3'd0:    rdata = dlab ? div[7:0] : rx_dout;
            3'd1:    rdata = dlab ? div[15:8] : {5'b0, ier};
            3'd2:    rdata = {4'b0, iid};
            3'd3:    rdata = {dlab, 7'b0000011};
            3'd4:    rdata = {5'b0, flow};
            3'd5:    rdata = lsr;
            3'd6:    rdata = {frac_mod, frac_add};
            default: rdata = 8'h00;
        endcase
    end

    // R1: a byte arriving at a full receive queue raises overrun
    p_overrun_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_full |=> lsr[1]);
    // R9: a stored byte with a low stop bit raises the framing flag
    p_frame_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_ferr && !rx_full |=> lsr[3]);
endmodule

// File: tb/serial_port_bench.sv
`timescale 1ns/1ps
module serial_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       rxd = 1'b1, txd, cts_n = 1'b0, rts_n, irq;

    int n_chk = 0, n_fail = 0;
    int bitclk = 16;

    always #2 clk = ~clk;

    serial_port u_serial_port (.clk, .rst_n, .addr, .wr_en, .rd_en, .wdata,
        .rdata, .rxd, .txd, .cts_n, .rts_n, .irq);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stopv);
        @(negedge clk); rxd = 1'b0;
        repeat (bitclk) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bitclk) @(negedge clk);
        end
        rxd = stopv;
        repeat (bitclk) @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_start(output bit ok);
        int w = 0;
        while (txd !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
        ok = (w < 3000);
    endtask

    task automatic recv_tx(input string req, input int exp, input bit drop_cts);
        bit ok;
        logic [7:0] b;
        wait_start(ok);
        if (!ok) begin chk({req, " start seen"}, 0, 1); return; end
        if (drop_cts) cts_n = 1'b1;
        repeat (bitclk/2) @(negedge clk);
        chk({req, " start bit"}, txd, 0);
        for (int i = 0; i < 8; i++) begin
            repeat (bitclk) @(negedge clk);
            b[i] = txd;
        end
        chk({req, " data"}, b, exp);
        repeat (bitclk) @(negedge clk);
        chk({req, " stop bit"}, txd, 1);
    endtask

    task automatic measure_low(output int w);
        bit ok;
        w = 0;
        wait_start(ok);
        while (ok && txd == 1'b0) begin w++; @(negedge clk); end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        chk("R12 txd idle", txd, 1);
        chk("R12 rts_n", rts_n, 1);
        chk("R12 irq", irq, 0);
        rd_chk("R12 line status", 3'd5, 8'h60);
        rd_chk("R12 interrupt id", 3'd2, 8'h01);
    endtask

    task automatic t_regmap;
        rd_chk("R3 line control", 3'd3, 8'h03);
        wr(3'd3, 8'h80);
        rd_chk("R3 divisor low reset", 3'd0, 8'h01);
        rd_chk("R3 divisor high reset", 3'd1, 8'h00);
        rd_chk("R3 line control dlab", 3'd3, 8'h83);
        wr(3'd0, 8'h07);
        rd_chk("R3 divisor low write", 3'd0, 8'h07);
        wr(3'd0, 8'h01);
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h05);
        rd_chk("R3 interrupt enable", 3'd1, 8'h05);
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h04);
        @(negedge clk);
        chk("R6 manual rts on", rts_n, 0);
        wr(3'd4, 8'h00);
        @(negedge clk);
        chk("R6 manual rts off", rts_n, 1);
    endtask

    task automatic t_tx;
        wr(3'd0, 8'hA5);
        recv_tx("R8 pattern A5", 8'hA5, 1'b0);
        repeat (bitclk + 4) @(negedge clk);
        wr(3'd0, 8'h01);
        recv_tx("R8 pattern 01", 8'h01, 1'b0);
        repeat (bitclk + 4) @(negedge clk);
        wr(3'd0, 8'h3C);
        repeat (20) @(negedge clk);
        rd_chk("R9 queue empty shifter busy", 3'd5, 8'h20);
        repeat (12 * bitclk) @(negedge clk);
        rd_chk("R9 transmitter empty", 3'd5, 8'h60);
    endtask

    task automatic t_baud;
        int w;
        wr(3'd3, 8'h80); wr(3'd0, 8'h03); wr(3'd3, 8'h00);
        wr(3'd0, 8'hFF);
        measure_low(w);
        chk("R4 integer divisor 3 start width", w, 48);
        repeat (600) @(negedge clk);
        wr(3'd3, 8'h80); wr(3'd0, 8'h02); wr(3'd3, 8'h00);
        wr(3'd6, 8'h21);
        wr(3'd0, 8'hFF);
        measure_low(w);
        chk("R4 fractional 2.5 start width", w, 40);
        repeat (500) @(negedge clk);
        wr(3'd3, 8'h80); wr(3'd0, 8'h01); wr(3'd3, 8'h00);
        wr(3'd6, 8'h10);
    endtask

    task automatic t_rx;
        send_rx(8'h96, 1'b1);
        rd_chk("R7 data ready", 3'd5, 8'h61);
        rd_chk("R7 mid-bit byte", 3'd0, 8'h96);
        rd_chk("R9 data ready clear", 3'd5, 8'h60);
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        rd_chk("R7 short pulse ignored", 3'd5, 8'h60);
    endtask

    task automatic t_overrun;
        wr(3'd2, 8'h06);
        for (int i = 0; i < 17; i++) send_rx(8'(8'h30 + i), 1'b1);
        rd_chk("R1 overrun set", 3'd5, 8'h63);
        rd_chk("R9 overrun clears on read", 3'd5, 8'h61);
        for (int i = 0; i < 16; i++) rd_chk("R1 queue order", 3'd0, 8'h30 + i);
        rd_chk("R1 queue drained", 3'd5, 8'h60);
    endtask

    task automatic t_trigger;
        wr(3'd1, 8'h01);
        wr(3'd4, 8'h01);
        wr(3'd2, 8'h46);
        for (int i = 0; i < 3; i++) send_rx(8'(8'h50 + i), 1'b1);
        rd_chk("R2 below trigger 4", 3'd2, 8'h01);
        chk("R6 rts below trigger", rts_n, 0);
        send_rx(8'h53, 1'b1);
        rd_chk("R2 at trigger 4", 3'd2, 8'h04);
        chk("R11 irq with data", irq, 1);
        chk("R6 rts at trigger", rts_n, 1);
        rd_chk("R2 first byte", 3'd0, 8'h50);
        rd_chk("R2 after read", 3'd2, 8'h01);
        chk("R6 rts after read", rts_n, 0);
        wr(3'd2, 8'h00);
        @(negedge clk);
        chk("R2 code 00 is one byte", rts_n, 1);
        wr(3'd2, 8'h80);
        @(negedge clk);
        chk("R2 code 10 is eight bytes", rts_n, 0);
        wr(3'd2, 8'h06);
        @(negedge clk);
        chk("R2 receive queue reset", rts_n, 0);
        rd_chk("R2 reset empties queue", 3'd5, 8'h60);
        wr(3'd4, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_timeout;
        wr(3'd1, 8'h01);
        wr(3'd2, 8'h46);
        send_rx(8'h11, 1'b1);
        send_rx(8'h22, 1'b1);
        rd_chk("R10 no timeout yet", 3'd2, 8'h01);
        repeat (700) @(negedge clk);
        rd_chk("R10 timeout", 3'd2, 8'h0C);
        chk("R10 irq", irq, 1);
        rd_chk("R10 byte", 3'd0, 8'h11);
        rd_chk("R10 read restarts timer", 3'd2, 8'h01);
        repeat (700) @(negedge clk);
        rd_chk("R10 timeout again", 3'd2, 8'h0C);
        rd_chk("R10 last byte", 3'd0, 8'h22);
        rd_chk("R10 empty no timeout", 3'd2, 8'h01);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h06);
    endtask

    task automatic t_priority;
        wr(3'd1, 8'h07);
        rd_chk("R11 tx empty id", 3'd2, 8'h02);
        send_rx(8'h7E, 1'b0);
        rd_chk("R11 line error first", 3'd2, 8'h06);
        rd_chk("R9 framing error", 3'd5, 8'h69);
        rd_chk("R11 data after line", 3'd2, 8'h04);
        rd_chk("R11 byte kept", 3'd0, 8'h7E);
        rd_chk("R11 tx empty last", 3'd2, 8'h02);
        chk("R11 irq for tx empty", irq, 1);
        wr(3'd1, 8'h00);
        rd_chk("R11 none", 3'd2, 8'h01);
        chk("R11 irq low", irq, 0);
    endtask

    task automatic t_cts;
        int lows = 0;
        wr(3'd4, 8'h02);
        cts_n = 1'b1;
        wr(3'd0, 8'h5A);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        chk("R5 blocked while cts high", lows, 0);
        cts_n = 1'b0;
        recv_tx("R5 released", 8'h5A, 1'b0);
        repeat (bitclk + 4) @(negedge clk);
        wr(3'd0, 8'h11);
        wr(3'd0, 8'h22);
        recv_tx("R5 in-progress completes", 8'h11, 1'b1);
        lows = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        chk("R5 next held", lows, 0);
        cts_n = 1'b0;
        recv_tx("R5 next after release", 8'h22, 1'b0);
        repeat (bitclk + 4) @(negedge clk);
        wr(3'd4, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset;
        t_regmap;
        t_tx;
        t_baud;
        t_rx;
        t_overrun;
        t_trigger;
        t_timeout;
        t_priority;
        t_cts;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule